// File: doc/BRIEF.md
# Four-Stage Shift Register with J-K Serial Entry

This block is a four-stage synchronous register with two operating modes, picked by one mode input. In load mode a rising clock edge copies a four-bit parallel word into the stages. In shift mode each rising edge moves the contents one stage onward, from the head stage (bit 0) toward the tail stage (bit 3).

In shift mode the head stage does not simply take a serial bit. It acts as a J-K flip-flop driven by a J input and an active-low K input. Depending on how those two inputs are tied, the head stage holds, clears, sets or toggles. Tying both inputs together turns it into a D-type entry. Tying them in opposite senses gives a toggle.

The register exposes all four stage values and the inverse of the tail stage, which a following stage can use. An active-low asynchronous clear empties the register at once and overrides every other input.

Top module: `jk_entry_shifter`

The design is organised around two decoded states. The mode state takes the values MODE_LOAD (mode input 0) and MODE_SHIFT (mode input 1). The head-action state is coded as {J, K_n}: JK_CLEAR = 00, JK_HOLD = 01, JK_TOGGLE = 10 and JK_SET = 11. On every rising edge the register moves either along the load transition (all stages take the parallel word) or along the shift transition (the head stage takes its J-K action and the other stages take their neighbour). The clear transition, to the all-zero state, can happen at any time.

## Requirements
- R1: While `clr_n` is 0, `stage_q` is 4'b0000 and `last_q_n` is 1 at once, with or without a clock edge.
- R2: With `shift_en` = 0, a rising clock edge loads `par_in` into `stage_q` bit for bit (bit 0 is the head stage).
- R3: During a load, `ser_j` and `ser_k_n` have no effect on any stage.
- R4: With `shift_en` = 1, a rising edge sets stage_q[1] to the old stage_q[0], stage_q[2] to the old stage_q[1] and stage_q[3] to the old stage_q[2].
- R5: In shift mode, `ser_j` = 0 with `ser_k_n` = 1 leaves stage_q[0] unchanged.
- R6: In shift mode, `ser_j` = 0 with `ser_k_n` = 0 sets stage_q[0] to 0.
- R7: In shift mode, `ser_j` = 1 with `ser_k_n` = 1 sets stage_q[0] to 1.
- R8: In shift mode, `ser_j` = 1 with `ser_k_n` = 0 sets stage_q[0] to the inverse of its previous value.
- R9: `last_q_n` is always the inverse of stage_q[3].
- R10: While `clr_n` is 1, the outputs keep their values between rising clock edges, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the register changes state on the rising edge |
| clr_n | input | 1 | Asynchronous clear, active low, highest priority |
| shift_en | input | 1 | Mode select: 1 = shift, 0 = parallel load |
| ser_j | input | 1 | J input of the head stage, used in shift mode |
| ser_k_n | input | 1 | Active-low K input of the head stage, used in shift mode |
| par_in | input | 4 | Parallel load word; bit 0 goes to the head stage |
| stage_q | output | 4 | Stage values; bit 0 is the head, bit 3 the tail |
| last_q_n | output | 1 | Inverse of the tail stage |

## Verification
The hardest case to reach is the toggle action. Its result depends on the head stage's own earlier value, so the bench first loads a known word and then runs toggles over several edges in a row, so that both the 0-to-1 and the 1-to-0 flips occur while the data still moves down the chain. The clear is asserted in the middle of a clock phase during a shift run, and the outputs are sampled before any edge to show that the clear acts without one. A load followed at once by a shift confirms that the mode takes effect on the very next edge.

// File: rtl/jkshift_pkg.sv
package jkshift_pkg;

    typedef enum logic {
        MODE_LOAD  = 1'b0,
        MODE_SHIFT = 1'b1
    } mode_e;

    // Coded as {J, K_n}
    typedef enum logic [1:0] {
        JK_CLEAR  = 2'b00,
        JK_HOLD   = 2'b01,
        JK_TOGGLE = 2'b10,
        JK_SET    = 2'b11
    } jk_action_e;

endpackage

// File: rtl/jk_head_stage.sv
module jk_head_stage
    import jkshift_pkg::*;
(
    input  jk_action_e act,
    input  logic       cur,
    output logic       nxt
);

    always_comb begin
        unique case (act)
            JK_HOLD:   nxt = cur;
            JK_CLEAR:  nxt = 1'b0;
            JK_SET:    nxt = 1'b1;
            JK_TOGGLE: nxt = ~cur;
            default:   nxt = cur;
        endcase
    end

endmodule

// File: rtl/shift_next.sv
module shift_next
    import jkshift_pkg::*;
#(
    parameter int STAGES = 4
) (
    input  mode_e             mode,
    input  logic [STAGES-1:0] cur,
    input  logic [STAGES-1:0] par,
    input  logic              head_nxt,
    output logic [STAGES-1:0] nxt
);

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_head
            always_comb begin
                unique case (mode)
                    MODE_LOAD:  nxt[i] = par[i];
                    MODE_SHIFT: nxt[i] = head_nxt;
                    default:    nxt[i] = cur[i];
                endcase
            end
        end else begin : g_body
            always_comb begin
                unique case (mode)
                    MODE_LOAD:  nxt[i] = par[i];
                    MODE_SHIFT: nxt[i] = cur[i-1];
                    default:    nxt[i] = cur[i];
                endcase
            end
        end
    end

endmodule

// File: rtl/jk_entry_shifter.sv
module jk_entry_shifter
    import jkshift_pkg::*;
#(
    parameter int STAGES = 4
) (
    input  logic              clk,
    input  logic              clr_n,
    input  logic              shift_en,
    input  logic              ser_j,
    input  logic              ser_k_n,
    input  logic [STAGES-1:0] par_in,
    output logic [STAGES-1:0] stage_q,
    output logic              last_q_n
);

    localparam int TAIL = STAGES - 1;

    mode_e             mode;
    jk_action_e        act;
    logic              head_nxt;
    logic [STAGES-1:0] state_q;
    logic [STAGES-1:0] state_d;

    always_comb begin
        mode = mode_e'(shift_en);
        act  = jk_action_e'({ser_j, ser_k_n});
    end

    jk_head_stage i_head (
        .act (act),
        .cur (state_q[0]),
        .nxt (head_nxt)
    );

    shift_next #(.STAGES(STAGES)) i_next (
        .mode     (mode),
        .cur      (state_q),
        .par      (par_in),
        .head_nxt (head_nxt),
        .nxt      (state_d)
    );

    // State register: asynchronous clear, otherwise rising-edge update
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) state_q <= '0;
        else        state_q <= state_d;
    end

    // Output process
    always_comb begin
        stage_q  = state_q;
        last_q_n = ~state_q[TAIL];
    end

    AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!clr_n) !shift_en |=> stage_q == $past(par_in)); // R2
    AST_SHIFT_MOVE: assert property (@(posedge clk) disable iff (!clr_n) shift_en |=> stage_q[TAIL:1] == $past(stage_q[TAIL-1:0])); // R4
    AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (!clr_n) (shift_en && !ser_j && ser_k_n) |=> stage_q[0] == $past(stage_q[0])); // R5
    AST_HEAD_CLEAR: assert property (@(posedge clk) disable iff (!clr_n) (shift_en && !ser_j && !ser_k_n) |=> !stage_q[0]); // R6
    AST_HEAD_SET: assert property (@(posedge clk) disable iff (!clr_n) (shift_en && ser_j && ser_k_n) |=> stage_q[0]); // R7
    AST_HEAD_TOGGLE: assert property (@(posedge clk) disable iff (!clr_n) (shift_en && ser_j && !ser_k_n) |=> stage_q[0] != $past(stage_q[0])); // R8

endmodule

// File: tb/test_jk_entry_shifter.sv
module test_jk_entry_shifter;

    logic       clk = 1'b0;
    logic       clr_n = 1'b0;
    logic       shift_en = 1'b0;
    logic       ser_j = 1'b0;
    logic       ser_k_n = 1'b0;
    logic [3:0] par_in = 4'b0000;
    logic [3:0] stage_q;
    logic       last_q_n;

    int   errors = 0;
    int   checks = 0;
    bit   done = 1'b0;
    logic [3:0] model = 4'b0000;

    always #10 clk = ~clk; // 50 MHz

    jk_entry_shifter i_jk_entry_shifter (
        .clk      (clk),
        .clr_n    (clr_n),
        .shift_en (shift_en),
        .ser_j    (ser_j),
        .ser_k_n  (ser_k_n),
        .par_in   (par_in),
        .stage_q  (stage_q),
        .last_q_n (last_q_n)
    );

    task automatic chk(input string req, input logic [3:0] exp_q);
        checks++;
        if (stage_q !== exp_q) begin
            errors++;
            $display("FAIL %s stage_q actual=%b expected=%b", req, stage_q, exp_q);
        end
        checks++;
        if (last_q_n !== ~exp_q[3]) begin
            errors++;
            $display("FAIL R9 last_q_n actual=%b expected=%b", last_q_n, ~exp_q[3]);
        end
    endtask

    // Drive at falling edge, clock once, update model, check at next falling edge
    task automatic step(input string req, input logic sh, input logic j,
                        input logic kn, input logic [3:0] d);
        shift_en = sh; ser_j = j; ser_k_n = kn; par_in = d;
        @(posedge clk);
        if (!sh) model = d;
        else begin
            logic head;
            case ({j, kn})
                2'b00:   head = 1'b0;
                2'b01:   head = model[0];
                2'b10:   head = ~model[0];
                default: head = 1'b1;
            endcase
            model = {model[2:0], head};
        end
        @(negedge clk);
        chk(req, model);
    endtask

    task automatic t_reset();
        #3;
        chk("R1 clear at start", 4'b0000);
        @(negedge clk);
        chk("R1 clear held over edge", 4'b0000);
        clr_n = 1'b1;
        model = 4'b0000;
    endtask

    task automatic t_load();
        step("R2 load 1010", 1'b0, 1'b0, 1'b1, 4'b1010);
        step("R3 load with J=1 K_n=0", 1'b0, 1'b1, 1'b0, 4'b0101);
        step("R3 load with J=1 K_n=1", 1'b0, 1'b1, 1'b1, 4'b1000);
        step("R2 load 1111", 1'b0, 1'b0, 1'b0, 4'b1111);
    endtask

    task automatic t_shift_jk();
        step("R2 preload", 1'b0, 1'b0, 1'b0, 4'b0110);
        step("R5 hold head", 1'b1, 1'b0, 1'b1, 4'b1111);
        step("R4 R5 hold again", 1'b1, 1'b0, 1'b1, 4'b0000);
        step("R6 clear head", 1'b1, 1'b0, 1'b0, 4'b1111);
        step("R7 set head", 1'b1, 1'b1, 1'b1, 4'b0000);
        step("R8 toggle head 1->0", 1'b1, 1'b1, 1'b0, 4'b1111);
        step("R8 toggle head 0->1", 1'b1, 1'b1, 1'b0, 4'b0000);
        step("R8 toggle head 1->0 again", 1'b1, 1'b1, 1'b0, 4'b0101);
        step("R4 shift with set", 1'b1, 1'b1, 1'b1, 4'b0000);
    endtask

    task automatic t_no_edge();
        step("R2 load 1001", 1'b0, 1'b0, 1'b0, 4'b1001);
        shift_en = 1'b0; par_in = 4'b0110; ser_j = 1'b1; ser_k_n = 1'b0;
        #4;
        shift_en = 1'b1;
        #4;
        chk("R10 no edge, inputs changed", model);
    endtask

    task automatic t_clear_mid();
        step("R2 load 1101", 1'b0, 1'b0, 1'b0, 4'b1101);
        step("R4 shift before clear", 1'b1, 1'b1, 1'b1, 4'b0000);
        #3;
        clr_n = 1'b0;
        #2;
        chk("R1 clear mid-cycle", 4'b0000);
        @(negedge clk);
        chk("R1 clear over edge", 4'b0000);
        clr_n = 1'b1;
        model = 4'b0000;
        step("R7 shift after clear", 1'b1, 1'b1, 1'b1, 4'b0000);
    endtask

    task automatic t_load_then_shift();
        step("R2 load 1001", 1'b0, 1'b1, 1'b1, 4'b1001);
        step("R4 R6 shift right after load", 1'b1, 1'b0, 1'b0, 4'b1111);
        step("R4 shift again", 1'b1, 1'b0, 1'b1, 4'b0000);
    endtask

    initial begin
        t_reset();
        @(negedge clk);
        t_load();
        t_shift_jk();
        t_no_edge();
        t_clear_mid();
        t_load_then_shift();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule